// File: doc/BRIEF.md
# Command packet stream decoder

This block sits behind a command fetch unit. It takes 32-bit command words one at a time over a valid/ready input and turns each packet into register or memory writes on a simple write port. The first word of a packet is a header. Its two top bits give the packet type. For the types that carry a body, a 14-bit count gives the body length.

Body words are used as they arrive and are never stored as a whole packet. A packet of the largest size therefore needs no buffer. The block keeps only the few arguments that a later word depends on.

Four packet kinds are supported: plain register bursts, the memory-write command, the end-of-pipe event and the two register-set commands. A few known commands are swallowed without effect. The end-of-pipe event may raise a one-cycle retired interrupt pulse. Malformed headers raise one-cycle error pulses.

Top module: `cmdpkt_decoder`

## Requirements
- R1: After reset, in_ready is 1 and wr_valid, retire, err_type and err_opcode are all 0.
- R2: A header with in_data[31:30]=0 starts a register burst of count+1 body words, where count is in_data[29:16]. Body word k (k=0,1,...) produces a 32-bit write of that word to address 0x0C200000 + (in_data[15:0] << 2) + 4k.
- R3: A header with type 2 is a one-word filler with no effect on any output. A type 1 header pulses err_type for one cycle in the cycle after it is accepted. The decoder stays idle, so the next word is taken as a header.
- R4: For a type 3 header, the opcode is in_data[15:8] and 0x3D selects memory-write. Its arguments are arg1 (address), arg2 (flags), arg3 and arg4. When flags bit 18 is 1, arg3 is written as 32 bits to arg1 with bits [1:0] cleared, on the arrival of arg3.
- R5: For memory-write with flags bit 18 at 0, {arg4, arg3} is written as one 64-bit write (wr_wide=1) to arg1 with bits [2:0] cleared, on the arrival of arg4.
- R6: For the end-of-pipe event, opcode 0x47, the address is arg2, the data-select field is arg3[31:29] and the interrupt-select field is arg3[25:24]. When interrupt-select is not 1, the writes depend on data-select:
  - Data-select 1 writes arg4 as 32 bits to the address aligned down to 4.
  - Data-select 2 writes arg4 to the address aligned down to 8, then arg5 to that address + 4, as two separate 32-bit writes.
  - Any other data-select value writes nothing.
- R7: An end-of-pipe event with interrupt-select 1 or 2 pulses retire for one cycle, in the cycle after its last word is accepted. Interrupt-select 0 or 3 gives no pulse.
- R8: Set-config (opcode 0x68) and set-context (opcode 0x69) take arg1 as a word index. They write arg2 onward as 32-bit words, starting at 0x0C208000 + arg1*4 or 0x0C228000 + arg1*4 and rising by 4 per word.
- R9: Opcodes 0x28, 0x32 and 0x44 consume their body with no write and no error. Any other unknown type 3 opcode also consumes its body with no write, and pulses err_opcode for one cycle after its header.
- R10: A write appears on the port for exactly one cycle, in the cycle after the word that caused it is accepted. in_ready is 0 in that cycle. 32-bit writes drive wr_data[63:32] to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted when in_valid and in_ready are both 1 |
| wr_valid | output | 1 | Write port strobe, one cycle per write |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 64 | Write data, low word only for 32-bit writes |
| wr_wide | output | 1 | 1 for a 64-bit write, 0 for a 32-bit write |
| retire | output | 1 | One-cycle retired interrupt pulse |
| err_type | output | 1 | One-cycle pulse on a type 1 header |
| err_opcode | output | 1 | One-cycle pulse on an unknown type 3 opcode |

## Verification
The bench goes after these corner cases, and what a faulty design would do on each:
- **Memory-write flag bit.** A design that tests the wrong flag bit would write 64 bits where 32 were asked, or the reverse.
- **Address alignment.** Memory-write and end-of-pipe addresses are given with their low bits set. A design that forgot to clear bits [1:0] or [2:0] would show the wrong address.
- **Split end-of-pipe data.** Data-select 2 with interrupt-select 2 must give two word writes and a retire pulse in the same cycle as the second write. Interrupt-select 1 must suppress the writes but keep the pulse.
- **Body length.** Unknown and swallowed opcodes are followed at once by a new packet. A decoder that counted the body length wrong, or stayed busy after a type 1 header, would treat a body word as a header and miss the next burst.

// File: rtl/cmdpkt_pkg.sv
package cmdpkt_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 14;
  localparam int LEN_W  = CNT_W + 1;
  localparam int IDX_W  = 3;

  localparam logic [WORD_W-1:0] REG0_BASE = 32'h0C20_0000;
  localparam logic [WORD_W-1:0] CFG_BASE  = 32'h0C20_8000;
  localparam logic [WORD_W-1:0] CTX_BASE  = 32'h0C22_8000;

  typedef enum logic [2:0] {
    K_REG0,
    K_MEMW,
    K_EOP,
    K_CFG,
    K_CTX,
    K_DROP
  } kind_e;

  typedef struct packed {
    logic                  req;
    logic                  wide;
    logic [WORD_W-1:0]     addr;
    logic [2*WORD_W-1:0]   data;
  } wr_req_t;

  // Start address of a plain register burst
  function automatic logic [WORD_W-1:0] reg0_addr(input logic [15:0] off);
    return REG0_BASE + {14'd0, off, 2'b00};
  endfunction

  // Word-indexed address inside a register-set window
  function automatic logic [WORD_W-1:0] set_addr(input logic [WORD_W-1:0] base,
                                                 input logic [WORD_W-1:0] idx);
    return base + {idx[WORD_W-3:0], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] align4(input logic [WORD_W-1:0] a);
    return {a[WORD_W-1:2], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] align8(input logic [WORD_W-1:0] a);
    return {a[WORD_W-1:3], 3'b000};
  endfunction

  // Body word index, saturating once past the last argument that matters
  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] i);
    return (&i) ? i : i + 1'b1;
  endfunction
endpackage

// File: rtl/cmdpkt_hdr_dec.sv
module cmdpkt_hdr_dec
  import cmdpkt_pkg::*;
#(
  parameter logic [7:0] OP_CTX_CTL = 8'h28,
  parameter logic [7:0] OP_IB      = 8'h32,
  parameter logic [7:0] OP_MEMW    = 8'h3D,
  parameter logic [7:0] OP_ME_INIT = 8'h44,
  parameter logic [7:0] OP_EOP     = 8'h47,
  parameter logic [7:0] OP_SET_CFG = 8'h68,
  parameter logic [7:0] OP_SET_CTX = 8'h69
) (
  input  logic [WORD_W-1:0] hdr,
  output logic              starts,
  output kind_e             kind,
  output logic              bad_type,
  output logic              bad_op,
  output logic [LEN_W-1:0]  plen
);
  logic [1:0] ptype;
  logic [7:0] op;

  assign ptype = hdr[31:30];
  assign op    = hdr[15:8];
  assign plen  = LEN_W'(hdr[29:16]) + LEN_W'(1);

  always_comb begin
    starts   = 1'b0;
    kind     = K_DROP;
    bad_type = 1'b0;
    bad_op   = 1'b0;
    case (ptype)
      2'd0: begin
        starts = 1'b1;
        kind   = K_REG0;
      end
      2'd3: begin
        starts = 1'b1;
        if (op == OP_MEMW)         kind = K_MEMW;
        else if (op == OP_EOP)     kind = K_EOP;
        else if (op == OP_SET_CFG) kind = K_CFG;
        else if (op == OP_SET_CTX) kind = K_CTX;
        else if (op == OP_CTX_CTL || op == OP_IB || op == OP_ME_INIT) kind = K_DROP;
        else bad_op = 1'b1;
      end
      2'd1:    bad_type = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/cmdpkt_exec.sv
module cmdpkt_exec
  import cmdpkt_pkg::*;
(
  input  kind_e             kind,
  input  logic [IDX_W-1:0]  idx,
  input  logic              last,
  input  logic [WORD_W-1:0] dw,
  input  logic [WORD_W-1:0] baddr,
  input  logic [WORD_W-1:0] mw_addr,
  input  logic              mw_d32,
  input  logic [WORD_W-1:0] mw_lo,
  input  logic [WORD_W-1:0] eop_addr,
  input  logic [2:0]        eop_dsel,
  input  logic [1:0]        eop_isel,
  output wr_req_t           req,
  output logic [WORD_W-1:0] baddr_nxt,
  output logic              retire_hit
);
  logic [1:0] isel_eff;

  always_comb begin
    req        = '0;
    baddr_nxt  = baddr;
    retire_hit = 1'b0;
    isel_eff   = (idx == IDX_W'(3)) ? dw[25:24] : eop_isel;
    case (kind)
      K_REG0: begin
        req.req   = 1'b1;
        req.addr  = baddr;
        req.data  = {32'd0, dw};
        baddr_nxt = baddr + 32'd4;
      end
      K_CFG, K_CTX: begin
        if (idx == IDX_W'(1)) begin
          baddr_nxt = set_addr((kind == K_CFG) ? CFG_BASE : CTX_BASE, dw);
        end else begin
          req.req   = 1'b1;
          req.addr  = baddr;
          req.data  = {32'd0, dw};
          baddr_nxt = baddr + 32'd4;
        end
      end
      K_MEMW: begin
        if (idx == IDX_W'(3) && mw_d32) begin
          req.req  = 1'b1;
          req.addr = align4(mw_addr);
          req.data = {32'd0, dw};
        end
        if (idx == IDX_W'(4) && !mw_d32) begin
          req.req  = 1'b1;
          req.wide = 1'b1;
          req.addr = align8(mw_addr);
          req.data = {dw, mw_lo};
        end
      end
      K_EOP: begin
        if (eop_isel != 2'd1) begin
          if (idx == IDX_W'(4) && eop_dsel == 3'd1) begin
            req.req  = 1'b1;
            req.addr = align4(eop_addr);
            req.data = {32'd0, dw};
          end
          if (idx == IDX_W'(4) && eop_dsel == 3'd2) begin
            req.req  = 1'b1;
            req.addr = align8(eop_addr);
            req.data = {32'd0, dw};
          end
          if (idx == IDX_W'(5) && eop_dsel == 3'd2) begin
            req.req  = 1'b1;
            req.addr = align8(eop_addr) + 32'd4;
            req.data = {32'd0, dw};
          end
        end
        if (last && idx >= IDX_W'(3) && (isel_eff == 2'd1 || isel_eff == 2'd2))
          retire_hit = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmdpkt_wr_port.sv
module cmdpkt_wr_port
  import cmdpkt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  wr_req_t             req,
  input  logic                retire_set,
  input  logic                bad_type_set,
  input  logic                bad_op_set,
  output logic                wr_valid,
  output logic [WORD_W-1:0]   wr_addr,
  output logic [2*WORD_W-1:0] wr_data,
  output logic                wr_wide,
  output logic                retire,
  output logic                err_type,
  output logic                err_opcode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      wr_wide    <= 1'b0;
      retire     <= 1'b0;
      err_type   <= 1'b0;
      err_opcode <= 1'b0;
    end else begin
      wr_valid   <= take & req.req;
      retire     <= take & retire_set;
      err_type   <= take & bad_type_set;
      err_opcode <= take & bad_op_set;
      if (take & req.req) begin
        wr_addr <= req.addr;
        wr_data <= req.data;
        wr_wide <= req.wide;
      end
    end
  end
endmodule

// File: rtl/cmdpkt_decoder.sv
module cmdpkt_decoder
  import cmdpkt_pkg::*;
#(
  parameter logic [7:0] OP_CTX_CTL = 8'h28,
  parameter logic [7:0] OP_IB      = 8'h32,
  parameter logic [7:0] OP_MEMW    = 8'h3D,
  parameter logic [7:0] OP_ME_INIT = 8'h44,
  parameter logic [7:0] OP_EOP     = 8'h47,
  parameter logic [7:0] OP_SET_CFG = 8'h68,
  parameter logic [7:0] OP_SET_CTX = 8'h69
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        wr_valid,
  output logic [31:0] wr_addr,
  output logic [63:0] wr_data,
  output logic        wr_wide,
  output logic        retire,
  output logic        err_type,
  output logic        err_opcode
);
  // Packet state
  logic              in_pkt;
  kind_e             kind;
  logic [LEN_W-1:0]  remain;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] baddr;
  logic [WORD_W-1:0] mw_addr;
  logic              mw_d32;
  logic [WORD_W-1:0] mw_lo;
  logic [WORD_W-1:0] eop_addr;
  logic [2:0]        eop_dsel;
  logic [1:0]        eop_isel;

  // Named events
  logic accept;
  logic hdr_take;
  logic pay_take;
  logic pkt_last;

  // Decoder outputs
  logic             hd_starts;
  kind_e            hd_kind;
  logic             hd_bad_type;
  logic             hd_bad_op;
  logic [LEN_W-1:0] hd_plen;

  wr_req_t           ex_req;
  wr_req_t           port_req;
  logic [WORD_W-1:0] ex_baddr_nxt;
  logic              ex_retire;

  assign in_ready = ~wr_valid;
  assign accept   = in_valid & in_ready;
  assign hdr_take = accept & ~in_pkt;
  assign pay_take = accept & in_pkt;
  assign pkt_last = (remain == LEN_W'(1));

  cmdpkt_hdr_dec #(
    .OP_CTX_CTL(OP_CTX_CTL), .OP_IB(OP_IB), .OP_MEMW(OP_MEMW),
    .OP_ME_INIT(OP_ME_INIT), .OP_EOP(OP_EOP),
    .OP_SET_CFG(OP_SET_CFG), .OP_SET_CTX(OP_SET_CTX)
  ) u_hdr (
    .hdr      (in_data),
    .starts   (hd_starts),
    .kind     (hd_kind),
    .bad_type (hd_bad_type),
    .bad_op   (hd_bad_op),
    .plen     (hd_plen)
  );

  cmdpkt_exec u_exec (
    .kind       (kind),
    .idx        (idx),
    .last       (pkt_last),
    .dw         (in_data),
    .baddr      (baddr),
    .mw_addr    (mw_addr),
    .mw_d32     (mw_d32),
    .mw_lo      (mw_lo),
    .eop_addr   (eop_addr),
    .eop_dsel   (eop_dsel),
    .eop_isel   (eop_isel),
    .req        (ex_req),
    .baddr_nxt  (ex_baddr_nxt),
    .retire_hit (ex_retire)
  );

  assign port_req = in_pkt ? ex_req : '0;

  cmdpkt_wr_port u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (accept),
    .req          (port_req),
    .retire_set   (in_pkt & ex_retire),
    .bad_type_set (~in_pkt & hd_bad_type),
    .bad_op_set   (~in_pkt & hd_bad_op),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .wr_wide      (wr_wide),
    .retire       (retire),
    .err_type     (err_type),
    .err_opcode   (err_opcode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      kind     <= K_DROP;
      remain   <= '0;
      idx      <= '0;
      baddr    <= '0;
      mw_addr  <= '0;
      mw_d32   <= 1'b0;
      mw_lo    <= '0;
      eop_addr <= '0;
      eop_dsel <= '0;
      eop_isel <= '0;
    end else if (hdr_take) begin
      if (hd_starts) begin
        in_pkt <= 1'b1;
        kind   <= hd_kind;
        remain <= hd_plen;
        idx    <= IDX_W'(1);
        baddr  <= reg0_addr(in_data[15:0]);
      end
    end else if (pay_take) begin
      remain <= remain - LEN_W'(1);
      idx    <= idx_step(idx);
      baddr  <= ex_baddr_nxt;
      if (pkt_last) in_pkt <= 1'b0;
      case (kind)
        K_MEMW: begin
          if (idx == IDX_W'(1)) mw_addr <= in_data;
          if (idx == IDX_W'(2)) mw_d32  <= in_data[18];
          if (idx == IDX_W'(3)) mw_lo   <= in_data;
        end
        K_EOP: begin
          if (idx == IDX_W'(2)) eop_addr <= in_data;
          if (idx == IDX_W'(3)) begin
            eop_dsel <= in_data[31:29];
            eop_isel <= in_data[25:24];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmdpkt_decoder_chk.sv
module cmdpkt_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic [31:0] in_data,
  input logic        wr_valid,
  input logic [31:0] wr_addr,
  input logic [63:0] wr_data,
  input logic        wr_wide,
  input logic        retire,
  input logic        err_type
);
  assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_wr_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(accept));

  assert_narrow_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_wide) |-> (wr_addr[1:0] == 2'b00 && wr_data[63:32] == 32'd0));

  assert_wide_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_wide) |-> (wr_addr[2:0] == 3'b000));

  assert_retire_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);

  assert_retire_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> $past(accept));

  assert_type1_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_type |-> ($past(accept) && $past(in_data[31:30]) == 2'b01 && !wr_valid));
endmodule

bind cmdpkt_decoder cmdpkt_decoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .in_data  (in_data),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .wr_wide  (wr_wide),
  .retire   (retire),
  .err_type (err_type)
);

// File: tb/cmdpkt_decoder_tb.sv
`timescale 1ns/1ps
module cmdpkt_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic        wr_wide;
  logic        retire;
  logic        err_type;
  logic        err_opcode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmdpkt_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_wide(wr_wide), .retire(retire),
    .err_type(err_type), .err_opcode(err_opcode)
  );

  // Vector: word | exp write | exp addr | exp data | exp wide | exp retire | req
  localparam int NV = 43;
  localparam logic [134:0] VEC [NV] = '{
    // R2 register burst, count 1, offset 0x10
    {32'h0001_0010, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd2},
    {32'h1111_1111, 1'b1, 32'h0C20_0040, 64'h1111_1111, 1'b0, 1'b0, 4'd2},
    {32'h2222_2222, 1'b1, 32'h0C20_0044, 64'h2222_2222, 1'b0, 1'b0, 4'd2},
    // R3 filler
    {32'h8000_0000, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd3},
    // R4 memory-write, 32-bit
    {32'hC003_3D00, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd4},
    {32'h1000_0007, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd4},
    {32'h0004_0000, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd4},
    {32'hDEAD_BEEF, 1'b1, 32'h1000_0004, 64'hDEAD_BEEF, 1'b0, 1'b0, 4'd4},
    {32'h0000_0055, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd4},
    // R5 memory-write, 64-bit
    {32'hC003_3D00, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd5},
    {32'h2000_000F, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd5},
    {32'h0000_0000, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd5},
    {32'hAAAA_0001, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd5},
    {32'hBBBB_0002, 1'b1, 32'h2000_0008, 64'hBBBB_0002_AAAA_0001, 1'b1, 1'b0, 4'd5},
    // R6 R7 end-of-pipe, data-select 2, interrupt-select 2
    {32'hC004_4700, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd6},
    {32'h0000_0000, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd6},
    {32'h3000_0006, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd6},
    {32'h4200_0000, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd6},
    {32'h1234_5678, 1'b1, 32'h3000_0000, 64'h1234_5678, 1'b0, 1'b0, 4'd6},
    {32'h9ABC_DEF0, 1'b1, 32'h3000_0004, 64'h9ABC_DEF0, 1'b0, 1'b1, 4'd7},
    // R7 end-of-pipe, data-select 1, interrupt-select 1: pulse, no write
    {32'hC004_4700, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd7},
    {32'h0000_0000, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd7},
    {32'h4000_0003, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd7},
    {32'h2100_0000, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd7},
    {32'h0000_0066, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd6},
    {32'h0000_0067, 1'b0, 32'h0, 64'h0, 1'b0, 1'b1, 4'd7},
    // R6 end-of-pipe, data-select 1, interrupt-select 0: write, no pulse
    {32'hC004_4700, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd6},
    {32'h0000_0000, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd6},
    {32'h4000_0003, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd6},
    {32'h2000_0000, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd6},
    {32'h0000_0077, 1'b1, 32'h4000_0000, 64'h0000_0077, 1'b0, 1'b0, 4'd6},
    {32'h0000_0078, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd7},
    // R8 set-config
    {32'hC002_6800, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd8},
    {32'h0000_0010, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd8},
    {32'h0000_00A1, 1'b1, 32'h0C20_8040, 64'h0000_00A1, 1'b0, 1'b0, 4'd8},
    {32'h0000_00A2, 1'b1, 32'h0C20_8044, 64'h0000_00A2, 1'b0, 1'b0, 4'd8},
    // R8 set-context
    {32'hC001_6900, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd8},
    {32'h0000_0003, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd8},
    {32'h0000_00B1, 1'b1, 32'h0C22_800C, 64'h0000_00B1, 1'b0, 1'b0, 4'd8},
    // R9 swallowed opcode 0x32
    {32'hC002_3200, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd9},
    {32'h0000_0001, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd9},
    {32'h0000_0002, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd9},
    {32'h0000_0003, 1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 4'd9}
  };

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Offer one word; return at the falling edge after it was accepted
  task automatic send(input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_write(input string tag, input logic [31:0] a,
                              input logic [63:0] d, input logic w);
    chk(wr_valid == 1'b1, {tag, " wr_valid"}, 64'(wr_valid), 64'd1);
    chk(wr_addr == a, {tag, " wr_addr"}, 64'(wr_addr), 64'(a));
    chk(wr_data == d, {tag, " wr_data"}, wr_data, d);
    chk(wr_wide == w, {tag, " wr_wide"}, 64'(wr_wide), 64'(w));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready in reset", 64'(in_ready), 64'd1);
    chk({wr_valid, retire, err_type, err_opcode} == 4'b0, "R1 outputs in reset",
        64'({wr_valid, retire, err_type, err_opcode}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && wr_valid == 1'b0, "R1 after release",
        64'({in_ready, wr_valid}), 64'b10);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [134:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      send(v[134:103]);
      if (v[102]) begin
        expect_write(tag, v[101:70], v[69:6], v[5]);
        chk(in_ready == 1'b0, {tag, " R10 ready low"}, 64'(in_ready), 64'd0);
      end else begin
        chk(wr_valid == 1'b0, {tag, " no write"}, 64'(wr_valid), 64'd0);
      end
      chk(retire == v[4], {tag, " retire"}, 64'(retire), 64'(v[4]));
      chk({err_type, err_opcode} == 2'b00, {tag, " no error"},
          64'({err_type, err_opcode}), 64'd0);
    end

    // R3 type 1 header flags and stays idle
    send(32'h4000_0000);
    chk(err_type == 1'b1, "R3 err_type pulse", 64'(err_type), 64'd1);
    chk(wr_valid == 1'b0, "R3 no write on type 1", 64'(wr_valid), 64'd0);
    @(negedge clk);
    chk(err_type == 1'b0, "R3 err_type one cycle", 64'(err_type), 64'd0);
    send(32'h0000_0000);
    chk(wr_valid == 1'b0, "R3 next header taken", 64'(wr_valid), 64'd0);
    send(32'h0000_CAFE);
    expect_write("R3 R2 burst after type 1", 32'h0C20_0000, 64'h0000_CAFE, 1'b0);

    // R9 unknown opcode: error pulse, body consumed exactly
    send(32'hC001_FF00);
    chk(err_opcode == 1'b1, "R9 err_opcode pulse", 64'(err_opcode), 64'd1);
    send(32'h0000_0001);
    chk(wr_valid == 1'b0 && err_opcode == 1'b0, "R9 body word 1 silent",
        64'({wr_valid, err_opcode}), 64'd0);
    send(32'h0000_0002);
    chk(wr_valid == 1'b0, "R9 body word 2 silent", 64'(wr_valid), 64'd0);
    send(32'h0000_0005);
    chk(wr_valid == 1'b0, "R9 following header", 64'(wr_valid), 64'd0);
    send(32'h0000_0BAD);
    expect_write("R9 burst after unknown", 32'h0C20_0014, 64'h0000_0BAD, 1'b0);

    // R9 swallowed opcode 0x28 gives no error
    send(32'hC000_2800);
    chk(err_opcode == 1'b0, "R9 no error on 0x28", 64'(err_opcode), 64'd0);
    send(32'h1234_0000);
    chk(wr_valid == 1'b0, "R9 0x28 body silent", 64'(wr_valid), 64'd0);

    // R10 write strobe timing
    send(32'h0001_0000);
    send(32'h0000_00C1);
    expect_write("R10 first burst word", 32'h0C20_0000, 64'h0000_00C1, 1'b0);
    chk(in_ready == 1'b0, "R10 ready low during write", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk(wr_valid == 1'b0 && in_ready == 1'b1, "R10 strobe one cycle",
        64'({wr_valid, in_ready}), 64'b01);
    send(32'h0000_00C2);
    expect_write("R10 second burst word", 32'h0C20_0004, 64'h0000_00C2, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule